// File: doc/BRIEF.md
# Timer Counter with Match Actions

This block is the counting core of a pulse-width peripheral. A counter register advances on count events. In timer mode the events come from an internal prescaler, which divides the clock by a programmable limit plus one. In the edge modes the events come from a chosen external capture pin, on its rising edges, its falling edges or both. Each capture pin passes through a two-flop synchronizer before its edges are detected.

A bank of match registers is compared against the counter. Each match register has three control bits. The first raises a sticky interrupt flag. The second wraps the counter to zero on the next count event. The third halts counting by clearing the run bit. Software reaches all state through a word-addressed write port and a combinational read port. Each match lane also drives a one-cycle hit strobe.

Top module: `tcm_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` is low and `match_hit` is all zero. The registers are CTRL 0x0 (bit 0 = run), SRC 0x1 ([1:0] source mode, [3:2] pin select), PRESC 0x2, PCNT 0x3, COUNT 0x4, MCTL 0x5, FLAGS 0x6 and MATCH n at 0x8+n.
- R2: In source mode 00 with run set, PCNT advances each clock and returns to 0 in the clock where it equals PRESC. That same clock is a count event, so COUNT rises by 1 every PRESC+1 clocks. With run clear, COUNT and PCNT hold.
- R3: In source modes 01, 10 and 11, COUNT rises by 1 on each rising, falling, or rising-and-falling edge of the selected synchronized pin, respectively. PCNT does not move in these modes.
- R4: Pin select 00 picks `cap_in[0]` and 01 picks `cap_in[1]`. Edges on the other pin are not counted. Select codes 10 and 11 yield no count events.
- R5: `match_hit[n]` pulses for one clock after a count event loads COUNT with the value of MATCH n. Software writes to COUNT never cause a pulse.
- R6: When MCTL bit 3n is set, a hit on lane n sets FLAGS bit n. The flag stays set until software writes 1 to that bit; writing 0 has no effect. If a set and a clear arrive in the same clock, the set wins. `irq` is the OR of all flags. When MCTL bit 3n is clear, the flag does not set.
- R7: When MCTL bit 3n+1 is set and COUNT equals MATCH n, the next count event loads 0 instead of COUNT+1, so one period spans MATCH n + 1 events.
- R8: When MCTL bit 3n+2 is set, a hit on lane n clears the run bit. No count event is taken in the clock of the hit, and COUNT and PCNT hold until software sets run again. Counting then resumes from the held values.
- R9: When several lanes match on the same value, all of their enabled actions apply. A stop wins over a pending zero-reload: COUNT holds at the match value, and the reload takes effect on the first event after run is set again.
- R10: A software write to COUNT or PCNT in a clock that also carries a count event takes the written value. A software write to CTRL wins over a stop in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | NUM_CAP | Asynchronous capture pins used as count sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for both write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | OR of all interrupt flags |
| match_hit | output | NUM_MATCH | One-clock strobe per match lane |

## Verification
The sharpest collision is a stop hit landing in the same clock as the next count event. With the prescale limit at zero, every clock is an event, so the stop must suppress the increment outright. The bench programs lane 0 to stop and lane 1, on the same value, to interrupt and reload. It then expects COUNT frozen at that value, run cleared and only the flag of lane 1 set. Setting run for a single clock must then yield COUNT 0. A second stop case uses a prescale limit of 2, so that a prescaler left running through the stop clock would show up in PCNT.

// File: rtl/tcm_pkg.sv
// Package: shared register map, source-mode encoding and match-action layout.
// Assumes a word-addressed register port of REG_AW address bits.
package tcm_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL  = 4'h0;
    localparam logic [REG_AW-1:0] A_SRC   = 4'h1;
    localparam logic [REG_AW-1:0] A_PRESC = 4'h2;
    localparam logic [REG_AW-1:0] A_PCNT  = 4'h3;
    localparam logic [REG_AW-1:0] A_COUNT = 4'h4;
    localparam logic [REG_AW-1:0] A_MCTL  = 4'h5;
    localparam logic [REG_AW-1:0] A_FLAGS = 4'h6;
    localparam int                A_MATCH_BASE = 8;

    // Count source: internal prescaler or edges of a capture pin.
    typedef enum logic [1:0] {
        SRC_TIMER = 2'b00,
        SRC_RISE  = 2'b01,
        SRC_FALL  = 2'b10,
        SRC_BOTH  = 2'b11
    } src_mode_e;

    // Three control bits per lane; irq_en sits at the lowest bit (3n).
    typedef struct packed {
        logic stop_en;
        logic rst_en;
        logic irq_en;
    } match_act_t;

endpackage

// File: rtl/tcm_cap_edge.sv
// Module: tcm_cap_edge
// Synchronizes the capture pins through two flops, detects edges on the
// synchronized levels and emits one count event per qualifying edge of the
// selected pin. Assumes the pins are asynchronous to clk. Select codes at or
// beyond NUM_IN produce no events.
module tcm_cap_edge
    import tcm_pkg::*;
#(
    parameter int NUM_IN = 2,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] cap_in,
    input  src_mode_e         mode,
    input  logic [SEL_W-1:0]  sel,
    output logic              edge_tick
);

    logic [NUM_IN-1:0] sync_a;
    logic [NUM_IN-1:0] sync_b;
    logic [NUM_IN-1:0] prev_b;
    logic [NUM_IN-1:0] rise;
    logic [NUM_IN-1:0] fall;
    logic              rise_sel;
    logic              fall_sel;

    // Two-flop synchronizer followed by one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_b <= '0;
        end else begin
            sync_a <= cap_in;
            sync_b <= sync_a;
            prev_b <= sync_b;
        end
    end

    // Per-pin edge flags from the synchronized level and its history.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
        assign rise[i] = sync_b[i] & ~prev_b[i];
        assign fall[i] = ~sync_b[i] & prev_b[i];
    end

    // Pick the edge flags of the selected pin; unknown codes select nothing.
    always_comb begin
        rise_sel = 1'b0;
        fall_sel = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (sel == SEL_W'(i)) begin
                rise_sel = rise[i];
                fall_sel = fall[i];
            end
        end
    end

    // Map the edge flags to a count event by source mode.
    always_comb begin
        case (mode)
            SRC_RISE: edge_tick = rise_sel;
            SRC_FALL: edge_tick = fall_sel;
            SRC_BOTH: edge_tick = rise_sel | fall_sel;
            default:  edge_tick = 1'b0;
        endcase
    end

    // Two rising edges of one synchronized pin cannot come in adjacent clocks.
    assert_no_adjacent_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tick && mode == SRC_RISE) |=> !(edge_tick && mode == SRC_RISE && $stable(sel)));

endmodule

// File: rtl/tcm_prescaler.sv
// Module: tcm_prescaler
// Prescale counter for timer mode. While active it steps every clock and
// returns to zero in the clock where it equals the limit; that clock is a
// count event. Assumes the parent gates 'active' with run, stop and mode.
// A software write takes priority over stepping.
module tcm_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [W-1:0] limit,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] pc,
    output logic         tick
);

    // A count event is due when the counter reaches the limit.
    assign tick = active && (pc == limit);

    // Step, wrap or load the prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (wr_en) begin
            pc <= wr_val;
        end else if (active) begin
            pc <= tick ? '0 : pc + 1'b1;
        end
    end

endmodule

// File: rtl/tcm_match_bank.sv
// Module: tcm_match_bank
// Compares every match lane against the counter. It registers a one-clock hit
// per lane when a count event loads the lane's value, and derives the lane
// actions: flag set and stop from the registered hit, and the zero-reload
// request from the live equality. Assumes 'load' excludes software writes.
module tcm_match_bank
    import tcm_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [W-1:0]        next_val,
    input  logic [W-1:0]        tc,
    input  logic [N-1:0][W-1:0] match_val,
    input  match_act_t [N-1:0]  act,
    output logic [N-1:0]        hit,
    output logic [N-1:0]        flag_set,
    output logic                rst_req,
    output logic                stop_req
);

    logic [N-1:0] hit_d;
    logic [N-1:0] eq_now;
    logic [N-1:0] rst_lane;
    logic [N-1:0] stop_lane;

    // Lane logic: next-hit compare, live equality and the action terms.
    for (genvar n = 0; n < N; n++) begin : g_lane
        assign hit_d[n]     = load && (next_val == match_val[n]);
        assign eq_now[n]    = (tc == match_val[n]);
        assign rst_lane[n]  = eq_now[n] & act[n].rst_en;
        assign stop_lane[n] = hit[n] & act[n].stop_en;
        assign flag_set[n]  = hit[n] & act[n].irq_en;

        // A hit always shows the counter sitting on the lane's value.
        assert_hit_on_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[n] && $stable(match_val[n])) |-> (tc == match_val[n]));
    end

    // Register the hits so each lasts exactly one clock per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= '0;
        end else begin
            hit <= hit_d;
        end
    end

    assign rst_req  = |rst_lane;
    assign stop_req = |stop_lane;

endmodule

// File: rtl/tcm_timer.sv
// Module: tcm_timer (top)
// Timer/counter with per-lane match actions. It holds the register file,
// selects the count source, steps the counter and applies the interrupt,
// zero-reload and stop actions from the match bank. Assumes CNT_W <= DATA_W
// and NUM_MATCH <= 8, so the match registers fit the address map.
module tcm_timer
    import tcm_pkg::*;
#(
    parameter int NUM_MATCH = 4,
    parameter int CNT_W     = 32,
    parameter int NUM_CAP   = 2,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAP-1:0]   cap_in,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq,
    output logic [NUM_MATCH-1:0] match_hit
);

    localparam int MCTL_W = 3 * NUM_MATCH;
    localparam int SEL_W  = 2;

    logic                        run;
    src_mode_e                   mode;
    logic [SEL_W-1:0]            sel;
    logic [CNT_W-1:0]            presc;
    logic [CNT_W-1:0]            tc;
    logic [CNT_W-1:0]            pc;
    match_act_t [NUM_MATCH-1:0]  act;
    logic [NUM_MATCH-1:0]        flags;
    logic [NUM_MATCH-1:0][CNT_W-1:0] mval;

    logic wr_ctrl, wr_src, wr_presc, wr_pcnt, wr_count, wr_mctl, wr_flags;
    logic is_timer, pre_active, pre_tick, cap_tick, tick_src, tick;
    logic rst_req, stop_now;
    logic [CNT_W-1:0]     next_tc;
    logic [NUM_MATCH-1:0] hit;
    logic [NUM_MATCH-1:0] flag_set;
    logic [NUM_MATCH-1:0] flag_clr;

    // Write decode for the fixed registers.
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_src   = wr_en && (addr == A_SRC);
    assign wr_presc = wr_en && (addr == A_PRESC);
    assign wr_pcnt  = wr_en && (addr == A_PCNT);
    assign wr_count = wr_en && (addr == A_COUNT);
    assign wr_mctl  = wr_en && (addr == A_MCTL);
    assign wr_flags = wr_en && (addr == A_FLAGS);

    // Configuration registers: source mode, pin select, prescale limit, actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= SRC_TIMER;
            sel   <= '0;
            presc <= '0;
            act   <= '0;
        end else begin
            if (wr_src) begin
                mode <= src_mode_e'(wdata[1:0]);
                sel  <= wdata[3:2];
            end
            if (wr_presc) presc <= wdata[CNT_W-1:0];
            if (wr_mctl)  act   <= wdata[MCTL_W-1:0];
        end
    end

    // Match value registers, one word each from A_MATCH_BASE upward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mval <= '0;
        end else begin
            for (int n = 0; n < NUM_MATCH; n++) begin
                if (wr_en && addr == REG_AW'(A_MATCH_BASE + n)) begin
                    mval[n] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    // Edge-counting front end for the capture pins.
    tcm_cap_edge #(
        .NUM_IN (NUM_CAP),
        .SEL_W  (SEL_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .mode      (mode),
        .sel       (sel),
        .edge_tick (cap_tick)
    );

    assign is_timer   = (mode == SRC_TIMER);
    assign pre_active = run && !stop_now && is_timer;

    // Internal prescaler for timer mode.
    tcm_prescaler #(
        .W (CNT_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (pre_active),
        .limit  (presc),
        .wr_en  (wr_pcnt),
        .wr_val (wdata[CNT_W-1:0]),
        .pc     (pc),
        .tick   (pre_tick)
    );

    // Count event: chosen source, gated by run and stop; a software write wins.
    assign tick_src = is_timer ? pre_tick : (cap_tick && run && !stop_now);
    assign tick     = tick_src && !wr_count;
    assign next_tc  = rst_req ? '0 : tc + 1'b1;

    // Match comparators and action terms.
    tcm_match_bank #(
        .N (NUM_MATCH),
        .W (CNT_W)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tick),
        .next_val  (next_tc),
        .tc        (tc),
        .match_val (mval),
        .act       (act),
        .hit       (hit),
        .flag_set  (flag_set),
        .rst_req   (rst_req),
        .stop_req  (stop_now)
    );

    // Timer counter: software load, else step or wrap on a count event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (wr_count) begin
            tc <= wdata[CNT_W-1:0];
        end else if (tick) begin
            tc <= next_tc;
        end
    end

    // Run bit: software write wins, otherwise a stop action clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (wr_ctrl) begin
            run <= wdata[0];
        end else if (stop_now) begin
            run <= 1'b0;
        end
    end

    // Sticky flags: write-one-to-clear, and a same-clock set wins.
    assign flag_clr = wr_flags ? wdata[NUM_MATCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    assign irq       = |flags;
    assign match_hit = hit;

    // Combinational read mux over the register map.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'(run);
            A_SRC:   rdata = DATA_W'({sel, mode});
            A_PRESC: rdata = DATA_W'(presc);
            A_PCNT:  rdata = DATA_W'(pc);
            A_COUNT: rdata = DATA_W'(tc);
            A_MCTL:  rdata = DATA_W'(act);
            A_FLAGS: rdata = DATA_W'(flags);
            default: begin
                for (int n = 0; n < NUM_MATCH; n++) begin
                    if (addr == REG_AW'(A_MATCH_BASE + n)) rdata = DATA_W'(mval[n]);
                end
            end
        endcase
    end

    // Counter only steps by one when no reload is pending.
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rst_req) |=> (tc == $past(tc) + 1'b1));

    // With run clear and no software load, the counter holds.
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(tc));

    // A pending reload sends the counter to zero.
    assert_reload_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rst_req) |=> (tc == '0));

    // A stop hit clears run unless software writes CTRL in that clock.
    assert_stop_clears_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && !wr_ctrl) |=> !run);

    // A stop hit freezes the prescale counter in its own clock.
    assert_stop_freezes_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && !wr_pcnt) |=> $stable(pc));

    // A stop wins over a pending reload in the same clock.
    assert_stop_beats_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_now && rst_req && !wr_count) |=> $stable(tc));

    // Lane checks on interrupt flags.
    for (genvar n = 0; n < NUM_MATCH; n++) begin : g_flag_chk
        assert_flag_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[n] && act[n].irq_en) |=> flags[n]);
        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[n] && !(wr_flags && wdata[n])) |=> flags[n]);
    end

endmodule

// File: tb/tcm_timer_test.sv
// Bench for tcm_timer: a table of capture-mode vectors walked by one loop,
// then directed tests for reset, prescaling, match actions and collisions.
module tcm_timer_test;
    import tcm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cap_in = 2'b00;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;
    logic [3:0]  match_hit;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    int  hc0 = 0;
    int  hc1 = 0;

    always #2 clk = ~clk;

    tcm_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_in    (cap_in),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq),
        .match_hit (match_hit)
    );

    // Hit pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (match_hit[0]) hc0++;
        if (match_hit[1]) hc1++;
    end

    // Capture-mode vectors: mode, select, pin pulsed, pulses, expected COUNT.
    localparam int NV = 8;
    localparam int V_MODE [NV] = '{1, 2, 3, 1, 3, 1, 1, 1};
    localparam int V_SEL  [NV] = '{0, 0, 0, 0, 1, 1, 2, 3};
    localparam int V_PIN  [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};
    localparam int V_NUM  [NV] = '{3, 3, 3, 3, 2, 2, 2, 2};
    localparam int V_EXP  [NV] = '{3, 3, 6, 0, 4, 0, 0, 0};

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        @(negedge clk);
    endtask

    task automatic pulse(int pin);
        cap_in[pin] = 1'b1;
        repeat (4) @(negedge clk);
        cap_in[pin] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int b0, b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers and outputs.
        for (int a = 0; a < 12; a++) begin
            if (a != 7) begin
                rd(4'(a), v);
                check("R1", $sformatf("reg %0d after reset", a), v, 0);
            end
        end
        check("R1", "irq after reset", 32'(irq), 0);
        check("R1", "match_hit after reset", 32'(match_hit), 0);

        // R2: prescale limit 3 over 15 counting clocks.
        wr(A_PRESC, 3);
        wr(A_COUNT, 0);
        wr(A_PCNT, 0);
        wr(A_CTRL, 1);
        repeat (14) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_COUNT, v); check("R2", "COUNT after 15 clocks, limit 3", v, 3);
        rd(A_PCNT, v);  check("R2", "PCNT after 15 clocks, limit 3", v, 3);
        repeat (6) @(negedge clk);
        rd(A_COUNT, v); check("R2", "COUNT holds with run clear", v, 3);

        // R10: software load of COUNT beats a same-clock event.
        wr(A_PRESC, 0);
        wr(A_COUNT, 0);
        wr(A_PCNT, 0);
        wr(A_CTRL, 1);
        repeat (5) @(negedge clk);
        wr(A_COUNT, 100);
        rd(A_COUNT, v); check("R10", "COUNT right after load", v, 100);
        wr(A_CTRL, 0);
        rd(A_COUNT, v); check("R10", "COUNT two events after load", v, 102);

        // R3 / R4: capture-mode table.
        for (int i = 0; i < NV; i++) begin
            string req;
            req = (i < 3) ? "R3" : "R4";
            wr(A_SRC, 32'(V_MODE[i] | (V_SEL[i] << 2)));
            wr(A_PRESC, 5);
            wr(A_COUNT, 0);
            wr(A_PCNT, 0);
            wr(A_CTRL, 1);
            for (int p = 0; p < V_NUM[i]; p++) pulse(V_PIN[i]);
            repeat (4) @(negedge clk);
            wr(A_CTRL, 0);
            rd(A_COUNT, v); check(req, $sformatf("vector %0d COUNT", i), v, 32'(V_EXP[i]));
            rd(A_PCNT, v);  check(req, $sformatf("vector %0d PCNT idle", i), v, 0);
        end
        wr(A_SRC, 0);

        // R5 / R6 / R7: lane 0 interrupt+reload at 4, lane 1 plain at 2, limit 1.
        wr(A_PRESC, 1);
        wr(A_COUNT, 0);
        wr(A_PCNT, 0);
        wr(4'(A_MATCH_BASE + 0), 4);
        wr(4'(A_MATCH_BASE + 1), 2);
        wr(A_MCTL, 32'b011);
        wr(A_FLAGS, 32'hF);
        #1; b0 = hc0; b1 = hc1; @(negedge clk);
        wr(A_CTRL, 1);
        repeat (29) @(negedge clk);
        wr(A_CTRL, 0);
        repeat (2) @(negedge clk);
        #1;
        check("R5", "lane 0 one-clock hits", 32'(hc0 - b0), 3);
        check("R5", "lane 1 one-clock hits", 32'(hc1 - b1), 3);
        @(negedge clk);
        rd(A_COUNT, v); check("R7", "COUNT wraps with period 5", v, 0);
        rd(A_FLAGS, v); check("R6", "only lane 0 flag set", v, 1);
        check("R6", "irq with flag set", 32'(irq), 1);
        wr(A_FLAGS, 0);
        rd(A_FLAGS, v); check("R6", "writing 0 leaves flag", v, 1);
        wr(A_FLAGS, 1);
        rd(A_FLAGS, v); check("R6", "writing 1 clears flag", v, 0);
        check("R6", "irq after clear", 32'(irq), 0);

        // R8: stop on lane 0 at 6 with limit 2.
        wr(A_PRESC, 2);
        wr(A_COUNT, 0);
        wr(A_PCNT, 0);
        wr(4'(A_MATCH_BASE + 0), 6);
        wr(A_MCTL, 32'b100);
        wr(A_CTRL, 1);
        repeat (30) @(negedge clk);
        rd(A_CTRL, v);  check("R8", "run cleared by stop", v, 0);
        rd(A_COUNT, v); check("R8", "COUNT held at stop value", v, 6);
        rd(A_PCNT, v);  check("R8", "PCNT held at stop", v, 0);
        rd(A_FLAGS, v); check("R6", "no flag without enable", v, 0);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_COUNT, v); check("R8", "COUNT after resume", v, 7);
        rd(A_PCNT, v);  check("R8", "PCNT after resume", v, 1);

        // R9: lane 0 stop and lane 1 interrupt+reload both at 3, limit 0.
        wr(A_PRESC, 0);
        wr(A_COUNT, 0);
        wr(A_PCNT, 0);
        wr(4'(A_MATCH_BASE + 0), 3);
        wr(4'(A_MATCH_BASE + 1), 3);
        wr(A_MCTL, 32'h1C);
        wr(A_FLAGS, 32'hF);
        wr(A_CTRL, 1);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); check("R9", "COUNT frozen at shared match", v, 3);
        rd(A_CTRL, v);  check("R9", "run cleared", v, 0);
        rd(A_FLAGS, v); check("R9", "lane 1 flag only", v, 2);
        check("R9", "irq raised", 32'(irq), 1);
        wr(A_CTRL, 1);
        wr(A_CTRL, 0);
        rd(A_COUNT, v); check("R9", "reload applied on first event", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule